// File: doc/BRIEF.md
# Triggered Circular Sample Recorder

This block records one sample word on every clock cycle into a ring of storage. The newest word always replaces the oldest one. A trigger strobe marks one sample. After the trigger the block keeps recording for a number of further cycles, and that number comes from a two-bit position select. It then freezes the ring so that a host can read it back through a plain address/data port. While the data is frozen, no new samples are taken.

A capture starts from idle with a run or auto-run command. A stop command ends the capture at once and keeps whatever has been recorded. After a run capture the block waits in idle, and the frozen data stays readable until the next command. After an auto-run capture the block re-arms by itself once the host has read the last valid entry. The readout is normalised: address 0 is always the oldest valid sample. The block reports how many entries are valid and where the trigger sample sits in that order.

Top module: `trace_capture`

## Requirements
- R1: After reset the block is idle. Armed, triggered, done and trigger-seen are all low, and the fill count is 0. Exactly one of idle, armed and triggered is high at any time.
- R2: While armed or triggered and no stop is given, each clock edge writes `sampleIn` into the ring. The fill count rises by one per write and saturates at DEPTH. Once the ring is full, the newest sample replaces the oldest.
- R3: Position select 0 keeps floor(DEPTH*92/100) samples before the trigger sample (117 for DEPTH 128). The trigger sample plus the following writes make up DEPTH minus that count (11).
- R4: Position select 1 keeps DEPTH/2 samples before the trigger sample and DEPTH/2 from the trigger sample onwards (64 and 64).
- R5: Position select 2 keeps floor(DEPTH*12/100) samples before the trigger sample (15). The trigger sample and what follows fill the rest (113).
- R6: With position select 3, a trigger raises the triggered status and records the trigger position, but recording goes on until a stop command.
- R7: A read request at address A returns, on the next clock edge, the sample at position A counted from the oldest valid sample. The reported trigger index uses the same order.
- R8: If fewer samples than the pre-trigger count were taken before the trigger, the trigger index equals the number taken. The fill count is that number plus the post-trigger count.
- R9: A stop while armed or triggered goes to idle on that edge without writing, and it raises done.
- R10: In idle nothing is written: the fill count holds, and trigger strobes change neither the trigger-seen flag nor the fill count.
- R11: A run command while armed or triggered is ignored and recording continues. Stop takes priority over run in the same cycle.
- R12: After an auto-run capture, a read of the last valid address (fill count minus 1) re-arms the block and clears the fill count on that edge. A stop command clears auto-run mode, and after that the same read leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and control clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | WIDTH | Sample word written on each recording cycle |
| trigIn | input | 1 | Trigger strobe, acted on while armed |
| runCmd | input | 1 | Start a single capture from idle |
| autoCmd | input | 1 | Start a self-re-arming capture from idle |
| stopCmd | input | 1 | End capture now, or cancel auto-run mode |
| posSel | input | 2 | Trigger position: 0 mostly before, 1 centre, 2 mostly after, 3 continuous |
| rdReq | input | 1 | Read request |
| rdAddr | input | AW | Read address, 0 is the oldest valid sample |
| stIdle | output | 1 | Not recording |
| stArmed | output | 1 | Recording, waiting for a trigger |
| stTriggered | output | 1 | Trigger seen, recording post-trigger samples |
| stDone | output | 1 | Frozen data available for readout |
| trigHit | output | 1 | A trigger was recorded in the current capture |
| trigIndex | output | AW | Readout address of the trigger sample |
| fillCount | output | AW+1 | Number of valid samples |
| rdData | output | WIDTH | Read data, one cycle after the request |

## Verification
The hardest situation to reach from the ports is auto-run re-arm. It needs a complete triggered capture, then a readout that walks exactly to the last valid entry, and the re-arm must happen on that read's edge without corrupting the data being returned. The bench streams a counting pattern into the block so that every stored word tells which cycle it came from. It then reads the whole frozen ring, checks the final word, and checks that the block is armed with an empty fill count right after that read. A second capture then runs with an immediate trigger and a short post window. After a stop, the same last-address read is repeated to show that the block stays idle.

// File: rtl/trace_capture_pkg.sv
package trace_capture_pkg;

  localparam logic [1:0] MODE_CONT = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRIG  = 2'd2
  } capState_e;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic wrEn;
    logic clearAll;
    logic markTrig;
  } capStrobe_t;

  // samples kept from the trigger sample onwards for a position mode
  function automatic int postCount(input int depth, input logic [1:0] mode);
    int pct;
    case (mode)
      2'd0:    pct = 92;
      2'd1:    pct = 50;
      2'd2:    pct = 12;
      default: pct = 0;
    endcase
    return depth - (depth * pct) / 100;
  endfunction

endpackage

// File: rtl/trace_capture_store.sv
module trace_capture_store
  import trace_capture_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       stb,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             rdReq,
  input  logic [AW-1:0]    rdAddr,
  output logic [AW:0]      fillCount,
  output logic [AW-1:0]    trigIndex,
  output logic             trigHit,
  output logic [WIDTH-1:0] rdData
);

  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [WIDTH-1:0] ring [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    trigPhys;
  logic [AW-1:0]    oldest;
  logic [AW-1:0]    rdPhys;

  // once full, the next write slot holds the oldest sample
  assign oldest    = (fillCount == FULL) ? wrPtr : '0;
  assign rdPhys    = oldest + rdAddr;
  assign trigIndex = trigPhys - oldest;

  always_ff @(posedge clk) begin
    if (stb.wrEn) ring[wrPtr] <= sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      fillCount <= '0;
      trigPhys  <= '0;
      trigHit   <= 1'b0;
      rdData    <= '0;
    end else begin
      if (rdReq) rdData <= ring[rdPhys];
      if (stb.clearAll) begin
        wrPtr     <= '0;
        fillCount <= '0;
        trigPhys  <= '0;
        trigHit   <= 1'b0;
      end else if (stb.wrEn) begin
        wrPtr <= wrPtr + 1'b1;
        if (fillCount != FULL) fillCount <= fillCount + 1'b1;
        if (stb.markTrig) begin
          trigPhys <= wrPtr;
          trigHit  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
  import trace_capture_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigIn,
  input  logic          runCmd,
  input  logic          autoCmd,
  input  logic          stopCmd,
  input  logic [1:0]    posSel,
  input  logic          rdReq,
  input  logic [AW-1:0] rdAddr,
  input  logic [AW:0]   fillCount,
  output capStrobe_t    stb,
  output logic          stIdle,
  output logic          stArmed,
  output logic          stTriggered,
  output logic          stDone
);

  capState_e   stateQ, stateN;
  logic        doneQ, doneN;
  logic        autoQ, autoN;
  logic [1:0]  modeQ, modeN;
  logic [AW:0] remainQ, remainN;
  logic [AW:0] postLen;
  logic        lastRead;

  assign postLen  = (AW+1)'(postCount(DEPTH, modeQ));
  assign lastRead = rdReq && (fillCount != '0) &&
                    ({1'b0, rdAddr} == fillCount - 1'b1);

  always_comb begin
    stateN  = stateQ;
    doneN   = doneQ;
    autoN   = autoQ;
    modeN   = modeQ;
    remainN = remainQ;
    stb     = '0;
    case (stateQ)
      ST_IDLE: begin
        if (stopCmd) begin
          autoN = 1'b0;
        end else if (runCmd || autoCmd) begin
          stb.clearAll = 1'b1;
          stateN = ST_ARMED;
          doneN  = 1'b0;
          autoN  = autoCmd && !runCmd;
          modeN  = posSel;
        end else if (doneQ && autoQ && lastRead) begin
          stb.clearAll = 1'b1;
          stateN = ST_ARMED;
          doneN  = 1'b0;
        end
      end
      ST_ARMED: begin
        if (stopCmd) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
          autoN  = 1'b0;
        end else begin
          stb.wrEn = 1'b1;
          if (trigIn) begin
            stb.markTrig = 1'b1;
            if (modeQ == MODE_CONT) begin
              stateN = ST_TRIG;
            end else if (postLen == (AW+1)'(1)) begin
              stateN = ST_IDLE;
              doneN  = 1'b1;
            end else begin
              stateN  = ST_TRIG;
              remainN = postLen - 1'b1;
            end
          end
        end
      end
      default: begin
        if (stopCmd) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
          autoN  = 1'b0;
        end else begin
          stb.wrEn = 1'b1;
          if (modeQ != MODE_CONT) begin
            if (remainQ == (AW+1)'(1)) begin
              stateN = ST_IDLE;
              doneN  = 1'b1;
            end else begin
              remainN = remainQ - 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      doneQ   <= 1'b0;
      autoQ   <= 1'b0;
      modeQ   <= '0;
      remainQ <= '0;
    end else begin
      stateQ  <= stateN;
      doneQ   <= doneN;
      autoQ   <= autoN;
      modeQ   <= modeN;
      remainQ <= remainN;
    end
  end

  assign stIdle      = (stateQ == ST_IDLE);
  assign stArmed     = (stateQ == ST_ARMED);
  assign stTriggered = (stateQ == ST_TRIG);
  assign stDone      = doneQ;

endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_capture_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             trigIn,
  input  logic             runCmd,
  input  logic             autoCmd,
  input  logic             stopCmd,
  input  logic [1:0]       posSel,
  input  logic             rdReq,
  input  logic [AW-1:0]    rdAddr,
  output logic             stIdle,
  output logic             stArmed,
  output logic             stTriggered,
  output logic             stDone,
  output logic             trigHit,
  output logic [AW-1:0]    trigIndex,
  output logic [AW:0]      fillCount,
  output logic [WIDTH-1:0] rdData
);

  capStrobe_t stb;

  trace_capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .runCmd(runCmd),
    .autoCmd(autoCmd), .stopCmd(stopCmd), .posSel(posSel),
    .rdReq(rdReq), .rdAddr(rdAddr), .fillCount(fillCount), .stb(stb),
    .stIdle(stIdle), .stArmed(stArmed), .stTriggered(stTriggered),
    .stDone(stDone)
  );

  trace_capture_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleIn(sampleIn),
    .rdReq(rdReq), .rdAddr(rdAddr), .fillCount(fillCount),
    .trigIndex(trigIndex), .trigHit(trigHit), .rdData(rdData)
  );

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rstN,
  input logic        trigIn,
  input logic        runCmd,
  input logic        autoCmd,
  input logic        stopCmd,
  input logic        rdReq,
  input logic        stIdle,
  input logic        stArmed,
  input logic        stTriggered,
  input logic        stDone,
  input logic        trigHit,
  input logic [AW:0] fillCount
);

  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  // R1
  state_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({stIdle, stArmed, stTriggered}));

  // R2
  fill_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stArmed || stTriggered) && !stopCmd && (fillCount < FULL)
    |=> fillCount == $past(fillCount) + 1'b1);

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL);

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stArmed || stTriggered) && stopCmd |=> stIdle && stDone);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stIdle && !runCmd && !autoCmd && !rdReq |=> $stable(fillCount) && $stable(trigHit));

  // R11
  run_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    stArmed && runCmd && !stopCmd |=> fillCount != '0);

endmodule

bind trace_capture trace_capture_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .trigIn(trigIn), .runCmd(runCmd),
  .autoCmd(autoCmd), .stopCmd(stopCmd), .rdReq(rdReq), .stIdle(stIdle),
  .stArmed(stArmed), .stTriggered(stTriggered), .stDone(stDone),
  .trigHit(trigHit), .fillCount(fillCount)
);

// File: tb/trace_capture_tb.sv
`timescale 1ns/100ps
module trace_capture_tb;

  localparam int DEPTH = 128;
  localparam int WIDTH = 8;
  localparam int AW = $clog2(DEPTH);

  typedef struct packed {
    logic [1:0]  pos;
    logic [15:0] preN;
    logic [15:0] expIdx;
    logic [15:0] expFill;
  } vec_t;

  // R3 R4 R5 full-ring cases, R8 partial-fill cases
  localparam vec_t VECS [5] = '{
    '{2'd0, 16'd200, 16'd117, 16'd128},
    '{2'd1, 16'd200, 16'd64,  16'd128},
    '{2'd2, 16'd200, 16'd15,  16'd128},
    '{2'd2, 16'd5,   16'd5,   16'd118},
    '{2'd0, 16'd0,   16'd0,   16'd11}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIDTH-1:0] sampleIn = '0;
  logic trigIn = 0, runCmd = 0, autoCmd = 0, stopCmd = 0, rdReq = 0;
  logic [1:0] posSel = '0;
  logic [AW-1:0] rdAddr = '0;
  logic stIdle, stArmed, stTriggered, stDone, trigHit;
  logic [AW-1:0] trigIndex;
  logic [AW:0] fillCount;
  logic [WIDTH-1:0] rdData;

  int checks = 0;
  int failures = 0;

  trace_capture #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .trigIn(trigIn),
    .runCmd(runCmd), .autoCmd(autoCmd), .stopCmd(stopCmd), .posSel(posSel),
    .rdReq(rdReq), .rdAddr(rdAddr), .stIdle(stIdle), .stArmed(stArmed),
    .stTriggered(stTriggered), .stDone(stDone), .trigHit(trigHit),
    .trigIndex(trigIndex), .fillCount(fillCount), .rdData(rdData)
  );

  always #2 clk = ~clk;

  // counting pattern: each stored word identifies its cycle
  initial forever begin
    @(posedge clk);
    #0.5 sampleIn = sampleIn + 1'b1;
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulseCmd(input logic isAuto);
    if (isAuto) autoCmd = 1'b1; else runCmd = 1'b1;
    tick();
    autoCmd = 1'b0;
    runCmd  = 1'b0;
  endtask

  task automatic readAt(input int a, output logic [WIDTH-1:0] v);
    rdReq  = 1'b1;
    rdAddr = AW'(a);
    tick();
    rdReq = 1'b0;
    v = rdData;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 400 && !stDone; i++) tick();
  endtask

  // arm, wait preN samples, trigger; returns the value of the trigger sample
  task automatic captureRun(input logic isAuto, input logic [1:0] p,
                            input int preN, output logic [WIDTH-1:0] tv);
    posSel = p;
    pulseCmd(isAuto);
    for (int i = 0; i < preN; i++) tick();
    tv = sampleIn;
    trigIn = 1'b1;
    tick();
    trigIn = 1'b0;
  endtask

  logic [WIDTH-1:0] tv, rv, firstVal;
  int ti, fc;

  initial begin
    #7 rstN = 1'b1;
    tick();
    // R1
    chk(stIdle && !stArmed && !stTriggered && !stDone && !trigHit, "R1 reset status", int'(stIdle), 1);
    chk(fillCount == 0, "R1 reset fill", int'(fillCount), 0);

    foreach (VECS[k]) begin
      captureRun(1'b0, VECS[k].pos, int'(VECS[k].preN), tv);
      waitDone();
      ti = int'(trigIndex);
      fc = int'(fillCount);
      chk(stDone && stIdle && trigHit, "R3/R4/R5 capture done", int'(stDone), 1);
      chk(ti == int'(VECS[k].expIdx), "R3 R4 R5 R8 trigger index", ti, int'(VECS[k].expIdx));
      chk(fc == int'(VECS[k].expFill), "R2 R8 fill count", fc, int'(VECS[k].expFill));
      readAt(ti, rv);
      chk(rv == tv, "R7 trigger sample", int'(rv), int'(tv));
      readAt(0, rv);
      chk(rv == WIDTH'(int'(tv) - ti), "R7 oldest sample", int'(rv), int'(WIDTH'(int'(tv) - ti)));
      readAt(fc - 1, rv);
      chk(rv == WIDTH'(int'(tv) + fc - 1 - ti), "R7 newest sample", int'(rv),
          int'(WIDTH'(int'(tv) + fc - 1 - ti)));
    end

    // R11 run while armed is ignored, R9 stop freezes without writing
    posSel = 2'd1;
    firstVal = sampleIn;
    pulseCmd(1'b0);
    firstVal = firstVal + 1'b1;
    for (int i = 0; i < 10; i++) tick();
    chk(fillCount == 10, "R2 fill while armed", int'(fillCount), 10);
    runCmd = 1'b1; tick(); runCmd = 1'b0;
    chk(stArmed && fillCount == 11, "R11 run ignored", int'(fillCount), 11);
    stopCmd = 1'b1; runCmd = 1'b1; tick(); stopCmd = 1'b0; runCmd = 1'b0;
    chk(stIdle && stDone && fillCount == 11, "R9 R11 stop freezes", int'(fillCount), 11);
    chk(!trigHit, "R9 no trigger recorded", int'(trigHit), 0);
    // R10 idle: no sampling, trigger ignored
    for (int i = 0; i < 5; i++) tick();
    trigIn = 1'b1; tick(); trigIn = 1'b0;
    chk(fillCount == 11 && !trigHit, "R10 idle holds", int'(fillCount), 11);
    readAt(0, rv);
    chk(rv == firstVal, "R7 R10 first sample kept", int'(rv), int'(firstVal));

    // R6 continuous: trigger does not end capture
    captureRun(1'b0, 2'd3, 200, tv);
    for (int i = 0; i < 20; i++) tick();
    chk(stTriggered && !stDone && trigHit, "R6 still recording", int'(stTriggered), 1);
    stopCmd = 1'b1; tick(); stopCmd = 1'b0;
    chk(stDone && int'(trigIndex) == 107, "R6 trigger index after stop", int'(trigIndex), 107);
    readAt(107, rv);
    chk(rv == tv, "R6 trigger sample", int'(rv), int'(tv));

    // R12 auto-run re-arms after the last valid read
    captureRun(1'b1, 2'd1, 200, tv);
    waitDone();
    chk(stDone && int'(trigIndex) == 64, "R12 auto capture", int'(trigIndex), 64);
    for (int a = 0; a < DEPTH - 1; a++) readAt(a, rv);
    chk(stIdle && stDone, "R12 idle until last read", int'(stIdle), 1);
    readAt(DEPTH - 1, rv);
    chk(rv == WIDTH'(int'(tv) + 63), "R12 last read data", int'(rv), int'(WIDTH'(int'(tv) + 63)));
    chk(stArmed && !stDone && fillCount == 0, "R12 re-armed", int'(stArmed), 1);
    tv = sampleIn;
    trigIn = 1'b1; tick(); trigIn = 1'b0;
    waitDone();
    chk(int'(fillCount) == 64 && trigIndex == 0, "R4 R8 second auto capture", int'(fillCount), 64);
    readAt(0, rv);
    chk(rv == tv, "R12 second capture data", int'(rv), int'(tv));
    stopCmd = 1'b1; tick(); stopCmd = 1'b0;
    readAt(63, rv);
    tick();
    chk(stIdle && stDone && fillCount == 64, "R12 stop cancels auto", int'(stArmed), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule